// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block turns a 32-bit one-bit-per-pixel bitmap word into a horizontal run of 8-bit colour pixels in a frame buffer. The host first programs a row, a start column, an end column, a foreground colour, a background colour and a plane mask through a small register port. It then writes the bitmap word. That one write launches the whole run. The engine issues one pixel write per accepted memory cycle. Each write carries a linear address, a colour byte and a per-bit write mask.

Bitmap bits are used from the most significant end. The leftmost pixel takes bit 31 and each following pixel takes the next lower bit. A run shorter than 32 pixels uses only the leading bits of the word. When a run finishes, the start column and the row each step by a programmable increment. The host can therefore stream consecutive words along a text line without rewriting the coordinates. A register write that arrives while a run is in progress is held off with the bus ready signal low. It is not dropped.

Top module: `glyph_expand_engine`

## Requirements
- R1: After reset the status word reads 0 (idle), the plane mask reads all ones (0xFF), and the row, start column, end column, colours and steps read 0.
- R2: A write to the bitmap register (address 9) while idle starts a run of N = ((end − start) mod 2^XW mod 32) + 1 pixels. Exactly N pixel writes are issued, one per cycle in which `mem_ready` is high. Status bit 28 reads 1 from the cycle after the bitmap write until the edge that accepts the last pixel.
- R3: Pixel i of a run (i = 0 … N−1) is written at column x = (start + i) mod 2^XW and address row·PITCH + x.
- R4: Pixel i takes bitmap bit 31 − i. For a short run, the bits below bit 32 − N have no effect.
- R5: A bitmap bit of 1 writes the foreground colour (address 6). A bit of 0 writes the background colour (address 7).
- R6: The plane mask (address 8) is presented on `mem_wmask` with every pixel. The bits of a stored pixel whose mask bit is 0 keep their old value.
- R7: The edge that accepts the last pixel also adds the x step (address 4) to the start column (address 2) and the y step (address 5) to the row (address 1), both modulo their widths. The end column (address 3) is left unchanged.
- R8: While `mem_req` is high and `mem_ready` is low, the request, address, data and mask hold steady and no pixel is skipped.
- R9: Any register write arriving while a run is active is held with `bus_ready` low until the run ends, and then takes effect. A run in progress keeps the colours it started with.
- R10: Registers at addresses 1 to 8 read back their value zero-extended. Address 0 is status with the busy flag at bit 28. The bitmap register and unused addresses read 0. Reads are always ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| bus_ready | output | 1 | Access completes on the edge where this is high |
| mem_req | output | 1 | Pixel write request |
| mem_addr | output | AW = clog2(PITCH·2^YW + 2^XW) | Linear pixel address |
| mem_data | output | PW | Pixel colour |
| mem_wmask | output | PW | Per-bit write enable (plane mask) |
| mem_ready | input | 1 | Memory accepts the pixel on this edge |

## Verification
The bitmap write is taken on edge k. The first pixel request is visible from the cycle after edge k. Pixel i is accepted on the (i+1)-th later edge at which `mem_ready` is high. The busy flag and the coordinate advance both change on the edge that accepts the last pixel. The bench therefore polls the status word until bit 28 clears, and only then compares the whole memory image, the pixel count and the advanced coordinates against its own prediction. It reads status one cycle after launching a 32-pixel run to catch the busy flag. It records the memory handshake at each falling edge, so that stall holding is judged on values that are stable until the next rising edge.

// File: rtl/glyph_pkg.sv
// Shared register addresses and status layout for the glyph expansion engine.
// Assumes a 4-bit word-addressed register port.
package glyph_pkg;
    typedef enum logic [3:0] {
        REG_STATUS = 4'd0,
        REG_ROW    = 4'd1,
        REG_XSTART = 4'd2,
        REG_XEND   = 4'd3,
        REG_XSTEP  = 4'd4,
        REG_YSTEP  = 4'd5,
        REG_FG     = 4'd6,
        REG_BG     = 4'd7,
        REG_PMASK  = 4'd8,
        REG_GLYPH  = 4'd9
    } reg_sel_e;

    localparam int BUSY_BIT = 28;
    localparam int RUN_CW   = 5;   // width of a run-length-minus-one count (32 pixels)
endpackage

// File: rtl/glyph_regfile.sv
// Register file and host port. It holds the coordinates, colours, steps and plane mask.
// It launches a run on a bitmap write, holds off every write while busy, and applies the
// post-run coordinate advance. Assumes XW >= RUN_CW and that run_done occurs only while busy.
module glyph_regfile
    import glyph_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10,
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    input  logic              busy,
    input  logic              run_done,
    output logic              start,
    output logic [RUN_CW-1:0] span_m1,
    output logic [YW-1:0]     row_q,
    output logic [XW-1:0]     xstart_q,
    output logic [PW-1:0]     fg_q,
    output logic [PW-1:0]     bg_q,
    output logic [PW-1:0]     pmask_q
);
    logic [XW-1:0] xend_q;
    logic [XW-1:0] xstep_q;
    logic [YW-1:0] ystep_q;
    logic          wr_ok;

    // Purpose: decide whether a write may complete this cycle and whether it launches a run.
    always_comb begin
        wr_ok     = bus_sel && bus_we && !busy;
        bus_ready = !(bus_sel && bus_we && busy);
        start     = wr_ok && (bus_addr == REG_GLYPH);
        span_m1   = RUN_CW'(xend_q - xstart_q);
    end

    // Purpose: register writes, and the coordinate advance when a run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            xstart_q <= '0;
            xend_q   <= '0;
            xstep_q  <= '0;
            ystep_q  <= '0;
            fg_q     <= '0;
            bg_q     <= '0;
            pmask_q  <= '1;
        end else if (wr_ok) begin
            case (bus_addr)
                REG_ROW:    row_q    <= bus_wdata[YW-1:0];
                REG_XSTART: xstart_q <= bus_wdata[XW-1:0];
                REG_XEND:   xend_q   <= bus_wdata[XW-1:0];
                REG_XSTEP:  xstep_q  <= bus_wdata[XW-1:0];
                REG_YSTEP:  ystep_q  <= bus_wdata[YW-1:0];
                REG_FG:     fg_q     <= bus_wdata[PW-1:0];
                REG_BG:     bg_q     <= bus_wdata[PW-1:0];
                REG_PMASK:  pmask_q  <= bus_wdata[PW-1:0];
                default: ;
            endcase
        end else if (run_done) begin
            xstart_q <= xstart_q + xstep_q;
            row_q    <= row_q + ystep_q;
        end
    end

    // Purpose: read-back multiplexer; status carries the busy flag.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STATUS: bus_rdata[BUSY_BIT] = busy;
            REG_ROW:    bus_rdata = 32'(row_q);
            REG_XSTART: bus_rdata = 32'(xstart_q);
            REG_XEND:   bus_rdata = 32'(xend_q);
            REG_XSTEP:  bus_rdata = 32'(xstep_q);
            REG_YSTEP:  bus_rdata = 32'(ystep_q);
            REG_FG:     bus_rdata = 32'(fg_q);
            REG_BG:     bus_rdata = 32'(bg_q);
            REG_PMASK:  bus_rdata = 32'(pmask_q);
            default: ;
        endcase
    end

    // R7: completion of a run steps the start column and row by the programmed increments
    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (xstart_q == $past(xstart_q) + $past(xstep_q)) &&
                     (row_q == $past(row_q) + $past(ystep_q)) && $stable(xend_q));
endmodule

// File: rtl/glyph_run_seq.sv
// Run sequencer. It latches the bitmap word and the start position on launch, then walks
// the run one pixel per accepted memory cycle, shifting the word left so that the current
// bit is always bit 31. Assumes start is never raised while busy.
module glyph_run_seq
    import glyph_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       word,
    input  logic [RUN_CW-1:0] span_m1,
    input  logic [XW-1:0]     xstart,
    input  logic [YW-1:0]     row,
    input  logic              mem_ready,
    output logic              busy,
    output logic              run_done,
    output logic [XW-1:0]     cur_x,
    output logic [YW-1:0]     cur_y,
    output logic              cur_bit
);
    logic              busy_q;
    logic [RUN_CW-1:0] remain_q;
    logic [31:0]       shreg_q;
    logic [XW-1:0]     x_q;
    logic [YW-1:0]     y_q;

    // Purpose: load a run on launch and step it on every accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            shreg_q  <= '0;
            x_q      <= '0;
            y_q      <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            remain_q <= span_m1;
            shreg_q  <= word;
            x_q      <= xstart;
            y_q      <= row;
        end else if (busy_q && mem_ready) begin
            if (remain_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                remain_q <= remain_q - RUN_CW'(1);
            end
            shreg_q <= {shreg_q[30:0], 1'b0};
            x_q     <= x_q + XW'(1);
        end
    end

    // Purpose: expose the current pixel and the completion strobe.
    always_comb begin
        busy     = busy_q;
        run_done = busy_q && mem_ready && (remain_q == '0);
        cur_x    = x_q;
        cur_y    = y_q;
        cur_bit  = shreg_q[31];
    end

    // R2: a run only ends on an edge where the memory accepted a pixel
    assert_end_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(mem_ready));
    // R3: a launch loads the programmed column and row as the first pixel position
    assert_launch_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q && (x_q == $past(xstart)) && (y_q == $past(row)));
    // R8: a refused pixel keeps the run where it is
    assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !mem_ready |=> busy_q && $stable(x_q) && $stable(shreg_q) && $stable(remain_q));
endmodule

// File: rtl/glyph_pixel_out.sv
// Pixel formatter. It forms the linear address row*PITCH + column, picks the foreground or
// background colour from the current bitmap bit, and passes the plane mask as a per-bit
// write enable. Purely combinational; assumes AW covers the largest address.
module glyph_pixel_out #(
    parameter int XW    = 10,
    parameter int YW    = 10,
    parameter int PITCH = 1024,
    parameter int PW    = 8,
    parameter int AW    = 21
) (
    input  logic          busy,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          cur_bit,
    input  logic [PW-1:0] fg,
    input  logic [PW-1:0] bg,
    input  logic [PW-1:0] pmask,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] mem_data,
    output logic [PW-1:0] mem_wmask
);
    // Purpose: build the memory write request for the current pixel.
    always_comb begin
        mem_req   = busy;
        mem_addr  = AW'(cur_y) * AW'(PITCH) + AW'(cur_x);
        mem_data  = cur_bit ? fg : bg;
        mem_wmask = pmask;
    end
endmodule

// File: rtl/glyph_expand_engine.sv
// Top of the glyph expansion engine: register port, run sequencer and pixel formatter.
// One write to the bitmap register draws up to 32 pixels of one row. Assumes the memory
// takes one pixel per cycle in which mem_ready is high.
module glyph_expand_engine
    import glyph_pkg::*;
#(
    parameter int XW    = 10,
    parameter int YW    = 10,
    parameter int PITCH = 1024,
    parameter int PW    = 8,
    localparam int AW   = $clog2(PITCH * (2 ** YW) + 2 ** XW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [3:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_ready,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] mem_data,
    output logic [PW-1:0] mem_wmask,
    input  logic          mem_ready
);
    logic              busy;
    logic              run_done;
    logic              start;
    logic [RUN_CW-1:0] span_m1;
    logic [YW-1:0]     row_q;
    logic [XW-1:0]     xstart_q;
    logic [PW-1:0]     fg_q;
    logic [PW-1:0]     bg_q;
    logic [PW-1:0]     pmask_q;
    logic [XW-1:0]     cur_x;
    logic [YW-1:0]     cur_y;
    logic              cur_bit;

    glyph_regfile #(.XW(XW), .YW(YW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .run_done(run_done), .start(start), .span_m1(span_m1),
        .row_q(row_q), .xstart_q(xstart_q), .fg_q(fg_q), .bg_q(bg_q), .pmask_q(pmask_q)
    );

    glyph_run_seq #(.XW(XW), .YW(YW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .word(bus_wdata), .span_m1(span_m1),
        .xstart(xstart_q), .row(row_q), .mem_ready(mem_ready),
        .busy(busy), .run_done(run_done), .cur_x(cur_x), .cur_y(cur_y), .cur_bit(cur_bit)
    );

    glyph_pixel_out #(.XW(XW), .YW(YW), .PITCH(PITCH), .PW(PW), .AW(AW)) u_pix (
        .busy(busy), .cur_x(cur_x), .cur_y(cur_y), .cur_bit(cur_bit),
        .fg(fg_q), .bg(bg_q), .pmask(pmask_q),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_wmask(mem_wmask)
    );

    // R8: a refused request is presented again unchanged on the next cycle
    assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data) &&
                                  $stable(mem_wmask));
endmodule

// File: tb/sim_glyph_expand_engine.sv
// Self-checking bench: a byte memory model behind the pixel port, a shadow image
// predicted from the requirements, directed corner cases and seeded random runs.
module sim_glyph_expand_engine;
    import glyph_pkg::*;

    localparam int XW    = 6;
    localparam int YW    = 5;
    localparam int PITCH = 64;
    localparam int PW    = 8;
    localparam int AW    = $clog2(PITCH * (2 ** YW) + 2 ** XW);
    localparam int MEMN  = 2 ** AW;
    localparam int XMOD  = 2 ** XW;
    localparam int YMOD  = 2 ** YW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ready;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [PW-1:0] mem_data;
    logic [PW-1:0] mem_wmask;
    logic          mem_ready = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    glyph_expand_engine #(.XW(XW), .YW(YW), .PITCH(PITCH), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_wmask(mem_wmask),
        .mem_ready(mem_ready)
    );

    logic [7:0] mem     [MEMN];
    logic [7:0] exp_mem [MEMN];
    int checks = 0, fails = 0, pix_cnt = 0, hold_err = 0, cycles = 0, last_stalls = 0;
    bit stall_mode = 1'b0;
    bit prev_stall = 1'b0;
    logic [AW-1:0] prev_addr;
    logic [7:0]    prev_data;

    // model of the programmed state
    int m_row = 0, m_x0 = 0, m_x1 = 0, m_xs = 0, m_ys = 0, exp_n = 0;
    logic [7:0] m_fg = 8'h00, m_bg = 8'h00, m_pm = 8'hFF;

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // memory side: drive ready, commit accepted pixels, watch held requests
    always @(negedge clk) begin
        if (prev_stall && rst_n) begin
            if (!mem_req || mem_addr != prev_addr || mem_data != prev_data) hold_err++;
        end
        mem_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
        if (rst_n && mem_req && mem_ready) begin
            mem[mem_addr] = (mem[mem_addr] & ~mem_wmask) | (mem_data & mem_wmask);
            pix_cnt++;
        end
        prev_stall = rst_n && mem_req && !mem_ready;
        prev_addr  = mem_addr;
        prev_data  = mem_data;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            report();
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        last_stalls = 0;
        while (!bus_ready) begin
            @(negedge clk); #1;
            last_stalls++;
        end
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_reg(input logic [3:0] a, input int v);
        bus_write(a, 32'(v));
        case (a)
            REG_ROW:    m_row = v % YMOD;
            REG_XSTART: m_x0  = v % XMOD;
            REG_XEND:   m_x1  = v % XMOD;
            REG_XSTEP:  m_xs  = v % XMOD;
            REG_YSTEP:  m_ys  = v % YMOD;
            REG_FG:     m_fg  = 8'(v);
            REG_BG:     m_bg  = 8'(v);
            REG_PMASK:  m_pm  = 8'(v);
            default: ;
        endcase
    endtask

    // expected image update per R2..R7
    task automatic predict(input logic [31:0] word);
        int n;
        n = (((m_x1 - m_x0 + XMOD) % XMOD) % 32) + 1;
        for (int i = 0; i < n; i++) begin
            int x, a;
            logic [7:0] px;
            x  = (m_x0 + i) % XMOD;
            a  = m_row * PITCH + x;
            px = word[31 - i] ? m_fg : m_bg;
            exp_mem[a] = (exp_mem[a] & ~m_pm) | (px & m_pm);
        end
        exp_n = n;
        m_x0  = (m_x0 + m_xs) % XMOD;
        m_row = (m_row + m_ys) % YMOD;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        do bus_read(REG_STATUS, s); while (s[BUSY_BIT]);
    endtask

    task automatic compare_mem(input string req);
        int bad;
        bad = -1;
        for (int a = 0; a < MEMN; a++) begin
            if (bad < 0 && mem[a] !== exp_mem[a]) bad = a;
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s pixel at address %0d: actual 0x%0h expected 0x%0h",
                     req, bad, mem[bad], exp_mem[bad]);
        end
    endtask

    task automatic finish_run(input string req, input int base);
        logic [31:0] d;
        wait_idle();
        check("R2", 32'(pix_cnt - base), 32'(exp_n), "pixel write count");
        compare_mem(req);
        bus_read(REG_XSTART, d);
        check("R7", d, 32'(m_x0), "advanced start column");
        bus_read(REG_ROW, d);
        check("R7", d, 32'(m_row), "advanced row");
    endtask

    task automatic run(input logic [31:0] word, input string req);
        int base;
        predict(word);
        base = pix_cnt;
        bus_write(REG_GLYPH, word);
        finish_run(req, base);
    endtask

    initial begin
        logic [31:0] d;
        int base;
        void'($urandom(32'd4242));
        for (int a = 0; a < MEMN; a++) begin
            mem[a] = 8'h00;
            exp_mem[a] = 8'h00;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(REG_STATUS, d); check("R1", d, 32'h0, "status after reset");
        bus_read(REG_PMASK, d);  check("R1", d, 32'hFF, "plane mask after reset");
        bus_read(REG_XSTART, d); check("R1", d, 32'h0, "start column after reset");
        bus_read(REG_FG, d);     check("R1", d, 32'h0, "foreground after reset");

        // R10: read-back and unused addresses
        set_reg(REG_ROW, 5);
        bus_read(REG_ROW, d);   check("R10", d, 32'd5, "row read-back");
        set_reg(REG_XSTEP, 32);
        bus_read(REG_XSTEP, d); check("R10", d, 32'd32, "x step read-back");
        bus_read(4'hF, d);      check("R10", d, 32'h0, "unused address");
        bus_read(REG_GLYPH, d); check("R10", d, 32'h0, "bitmap register read");

        // R2/R3/R5: full 32-pixel run, busy visible while running
        set_reg(REG_YSTEP, 0); set_reg(REG_FG, 8'h5A); set_reg(REG_BG, 8'h11);
        set_reg(REG_PMASK, 8'hFF); set_reg(REG_ROW, 1);
        set_reg(REG_XSTART, 0); set_reg(REG_XEND, 31);
        predict(32'h8000_0001);
        base = pix_cnt;
        bus_write(REG_GLYPH, 32'h8000_0001);
        bus_read(REG_STATUS, d);
        check("R2", 32'(d[BUSY_BIT]), 32'd1, "busy during run");
        finish_run("R3 R5 full word", base);

        // R4: short run ignores the low bits
        set_reg(REG_ROW, 2); set_reg(REG_XSTART, 40); set_reg(REG_XEND, 43);
        run(32'hA000_FFFF, "R4 short run");

        // R6: plane mask keeps unmasked bits of stored pixels
        set_reg(REG_PMASK, 8'h0F); set_reg(REG_FG, 8'hC3); set_reg(REG_BG, 8'h3C);
        set_reg(REG_ROW, 1); set_reg(REG_XSTART, 0); set_reg(REG_XEND, 15);
        run(32'hFF00_0000, "R6 plane mask");
        set_reg(REG_PMASK, 8'hFF);

        // R7: both steps applied, back-to-back runs without reprogramming
        set_reg(REG_XSTEP, 8); set_reg(REG_YSTEP, 1);
        set_reg(REG_ROW, 3); set_reg(REG_XSTART, 10); set_reg(REG_XEND, 17);
        run(32'h5500_0000, "R7 first stepped run");
        run(32'hF0F0_F0F0, "R7 second stepped run");

        // R3: column wrap inside a run
        set_reg(REG_XSTEP, 32); set_reg(REG_YSTEP, 0);
        set_reg(REG_ROW, 4); set_reg(REG_XSTART, 60); set_reg(REG_XEND, 3);
        run(32'hC300_0000, "R3 column wrap");

        // R9: write during a run is held and applied afterwards
        set_reg(REG_FG, 8'h77); set_reg(REG_ROW, 6);
        set_reg(REG_XSTART, 0); set_reg(REG_XEND, 31);
        predict(32'hFFFF_FFFF);
        base = pix_cnt;
        bus_write(REG_GLYPH, 32'hFFFF_FFFF);
        bus_write(REG_FG, 32'h99);
        check("R9", 32'(last_stalls > 0), 32'd1, "write stalled while busy");
        m_fg = 8'h99;
        finish_run("R9 old colour kept", base);
        bus_read(REG_FG, d); check("R9", d, 32'h99, "held write applied");

        // R8: random runs under memory back-pressure
        stall_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            int len, x0;
            len = ($urandom % 32) + 1;
            x0  = $urandom % XMOD;
            set_reg(REG_FG, $urandom % 256);
            set_reg(REG_BG, $urandom % 256);
            set_reg(REG_PMASK, (k % 4 == 0) ? ($urandom % 256) : 255);
            set_reg(REG_ROW, $urandom % YMOD);
            set_reg(REG_XSTEP, (k % 5 == 0) ? ($urandom % XMOD) : 32);
            set_reg(REG_YSTEP, (k % 7 == 0) ? ($urandom % YMOD) : 0);
            set_reg(REG_XSTART, x0);
            set_reg(REG_XEND, (x0 + len - 1) % XMOD);
            run($urandom, "R8 random run");
        end
        stall_mode = 1'b0;
        check("R8", 32'(hold_err), 32'd0, "held requests changed");
        report();
    end
endmodule